// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests from three kinds of source: external request pins, on-chip peripheral lines and one non-maskable pin. Each maskable source carries its own programmable priority. Every cycle the block picks the single most urgent pending request. It then presents that request to the processor on registered outputs, together with the request's level and a code that identifies the source. The processor compares the level against its own mask input and, once it takes the interrupt, pulses an acknowledge. The acknowledge stores the source code in a readable vector register.

Each external pin can be set to one of four sense modes. Edge-sensed requests are held in pending flags that software clears. A status bit shows the synchronized level of the non-maskable pin, so a service routine can filter glitches on that pin in software. An active-low request pin tells an external bus master that an interrupt is waiting, so the master can release the bus. Configuration uses a simple register bus: a write strobe, an address and write data, with the read data registered one cycle after the address.

Top module: `prio_intc`

## Requirements
- R1: Each source has a 4-bit priority, and a priority of 0 blocks that source completely. Sources 0..3 are the external pins and sources 4..7 are the peripheral lines. Register 0 holds the priorities of sources 0..3 and register 1 those of sources 4..7, 4 bits per source with the lowest source in the low nibble.
- R2: Among active sources with nonzero priority, the highest priority wins. On a tie, the lower source index wins. The outputs show the winner's priority on `cpu_level` and its index on `cpu_code`.
- R3: A maskable winner raises `cpu_req` only when its priority is strictly greater than `cpu_mask`. When nothing is raised, `cpu_req`, `cpu_level` and `cpu_code` are 0.
- R4: Register 2 holds 2 bits of sense mode for each external pin, pin n at bits [2n+1:2n]. The codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge. In the two level modes the request follows the synchronized pin.
- R5: In the two edge modes a detected edge sets a pending flag that stays set until software writes 1 to bit n of register 3. Reading register 3 returns the pending flags. If an edge and a clear arrive in the same cycle, the edge wins.
- R6: A non-maskable pin edge sets a non-maskable pending flag. The edge is falling when bit 1 of register 4 is 0 and rising when it is 1. While the flag is set, the block raises `cpu_req` with level 15 and code 8, ignoring `cpu_mask` and every other source. An acknowledge of that request clears the flag.
- R7: Register 4 bit 0 always reads the synchronized level of the non-maskable pin. Bit 2 reads the non-maskable pending flag.
- R8: `req_out_n` is low while any active source with nonzero priority, or a non-maskable request, is pending. The mask has no effect on it.
- R9: When `cpu_ack` is high while `cpu_req` is high, register 5 takes the presented `cpu_code`.
- R10: Every pin passes through two synchronizer flops. A level-sensed pin change reaches the outputs on the third clock edge. An edge-sensed change reaches the outputs on the fourth clock edge. A peripheral line reaches the outputs on the first clock edge.
- R11: After reset all registers read 0, `cpu_req` is 0 and `req_out_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for the address of the previous cycle |
| ext_irq | input | 4 | External request pins |
| periph_irq | input | 4 | On-chip peripheral request lines |
| nmi_pin | input | 1 | Non-maskable request pin |
| cpu_mask | input | 4 | Processor's current mask level |
| cpu_ack | input | 1 | Processor acknowledge |
| cpu_req | output | 1 | Interrupt request to the processor |
| cpu_level | output | 4 | Priority of the presented request |
| cpu_code | output | 4 | Source code of the presented request |
| req_out_n | output | 1 | Active-low pending indication for a bus master |

## Verification
The outputs are registered, so a change on a peripheral line is due on the next edge. A level-sensed pin change is due after three edges: two synchronizer flops and the output register. An edge-sensed pin change is due after four edges, because the pending flag adds one more. Register reads are due one edge after the address. The bench drives inputs on falling edges, advances its behavioural model on rising edges using the inputs set before them, and compares every output at the following falling edge. Directed checks sample at those exact counts, including a check that a level-pin change is still absent one edge early.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_FALL = 2'b11
  } sense_e;
endpackage

// File: rtl/intc_pin_sync.sv
module intc_pin_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      lvl    <= '0;
      prv    <= '0;
    end else begin
      meta_q <= din;
      lvl    <= meta_q;
      prv    <= lvl;
    end
  end
endmodule

// File: rtl/intc_ext_sense.sv
module intc_ext_sense
  import prio_intc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   lvl,
  input  logic [N-1:0]   prv,
  input  logic [2*N-1:0] mode,
  input  logic           clr_we,
  input  logic [N-1:0]   clr_mask,
  output logic [N-1:0]   pend_o,
  output logic [N-1:0]   req_o
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    sense_e sm;
    logic   edge_hit;

    assign sm = sense_e'(mode[2*i +: 2]);

    always_comb begin
      unique case (sm)
        SENSE_RISE: edge_hit = lvl[i] & ~prv[i];
        SENSE_FALL: edge_hit = ~lvl[i] & prv[i];
        default:    edge_hit = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst)                        pend_q[i] <= 1'b0;
      else if (edge_hit)              pend_q[i] <= 1'b1;
      else if (clr_we && clr_mask[i]) pend_q[i] <= 1'b0;
    end

    always_comb begin
      unique case (sm)
        SENSE_LOW:  req_o[i] = ~lvl[i];
        SENSE_HIGH: req_o[i] = lvl[i];
        default:    req_o[i] = pend_q[i];
      endcase
    end

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (pend_q[i] && !(clr_we && clr_mask[i])) |=> pend_q[i]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 4
) (
  input  logic [NSRC-1:0]        req,
  input  logic [NSRC*PRIO_W-1:0] prio,
  output logic                   any,
  output logic [IDX_W-1:0]       win_idx,
  output logic [PRIO_W-1:0]      win_prio
);
  always_comb begin
    any      = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (prio[i*PRIO_W +: PRIO_W] > win_prio)) begin
        any      = 1'b1;
        win_prio = prio[i*PRIO_W +: PRIO_W];
        win_idx  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N_EXT    = 4,
  parameter int N_PERIPH = 4,
  parameter int PRIO_W   = 4,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [N_EXT-1:0]    ext_irq,
  input  logic [N_PERIPH-1:0] periph_irq,
  input  logic                nmi_pin,
  input  logic [PRIO_W-1:0]   cpu_mask,
  input  logic                cpu_ack,
  output logic                cpu_req,
  output logic [PRIO_W-1:0]   cpu_level,
  output logic [3:0]          cpu_code,
  output logic                req_out_n
);
  localparam int NSRC       = N_EXT + N_PERIPH;
  localparam int CODE_W     = 4;
  localparam int PER_WORD   = DATA_W / PRIO_W;
  localparam int PRIO_WORDS = (NSRC + PER_WORD - 1) / PER_WORD;
  localparam int A_MODE     = PRIO_WORDS;
  localparam int A_PEND     = PRIO_WORDS + 1;
  localparam int A_STAT     = PRIO_WORDS + 2;
  localparam int A_VEC      = PRIO_WORDS + 3;
  localparam logic [CODE_W-1:0] NMI_CODE = CODE_W'(NSRC);

  logic [PRIO_WORDS*DATA_W-1:0] prio_q;
  logic [2*N_EXT-1:0]           mode_q;
  logic                         nmi_rise_q, nmi_pend_q;
  logic [CODE_W-1:0]            vec_q;

  logic [N_EXT-1:0] ext_lvl, ext_prv, ext_pend, ext_req;
  logic             nmi_lvl, nmi_prv, nmi_edge, nmi_taken;
  logic             any;
  logic [CODE_W-1:0] win_idx;
  logic [PRIO_W-1:0] win_prio;
  logic             clr_we;

  intc_pin_sync #(.W(N_EXT)) u_ext_sync (
    .clk(clk), .rst(rst), .din(ext_irq), .lvl(ext_lvl), .prv(ext_prv));

  intc_pin_sync #(.W(1)) u_nmi_sync (
    .clk(clk), .rst(rst), .din(nmi_pin), .lvl(nmi_lvl), .prv(nmi_prv));

  assign clr_we = reg_we && (reg_addr == ADDR_W'(A_PEND));

  intc_ext_sense #(.N(N_EXT)) u_sense (
    .clk(clk), .rst(rst), .lvl(ext_lvl), .prv(ext_prv), .mode(mode_q),
    .clr_we(clr_we), .clr_mask(reg_wdata[N_EXT-1:0]),
    .pend_o(ext_pend), .req_o(ext_req));

  intc_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(CODE_W)) u_arb (
    .req({periph_irq, ext_req}), .prio(prio_q[NSRC*PRIO_W-1:0]),
    .any(any), .win_idx(win_idx), .win_prio(win_prio));

  // configuration registers
  for (genvar k = 0; k < PRIO_WORDS; k++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst) prio_q[k*DATA_W +: DATA_W] <= '0;
      else if (reg_we && reg_addr == ADDR_W'(k))
        prio_q[k*DATA_W +: DATA_W] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      nmi_rise_q <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_W'(A_MODE)) mode_q     <= reg_wdata[2*N_EXT-1:0];
      if (reg_addr == ADDR_W'(A_STAT)) nmi_rise_q <= reg_wdata[1];
    end
  end

  // non-maskable request
  assign nmi_edge  = nmi_rise_q ? (nmi_lvl & ~nmi_prv) : (~nmi_lvl & nmi_prv);
  assign nmi_taken = cpu_ack && cpu_req && (cpu_code == NMI_CODE);

  always_ff @(posedge clk) begin
    if (rst)            nmi_pend_q <= 1'b0;
    else if (nmi_edge)  nmi_pend_q <= 1'b1;
    else if (nmi_taken) nmi_pend_q <= 1'b0;
  end

  // vector latch
  always_ff @(posedge clk) begin
    if (rst)                     vec_q <= '0;
    else if (cpu_ack && cpu_req) vec_q <= cpu_code;
  end

  // registered request outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_req   <= 1'b0;
      cpu_level <= '0;
      cpu_code  <= '0;
      req_out_n <= 1'b1;
    end else begin
      req_out_n <= ~(nmi_pend_q | any);
      if (nmi_pend_q) begin
        cpu_req   <= 1'b1;
        cpu_level <= '1;
        cpu_code  <= NMI_CODE;
      end else if (any && (win_prio > cpu_mask)) begin
        cpu_req   <= 1'b1;
        cpu_level <= win_prio;
        cpu_code  <= win_idx;
      end else begin
        cpu_req   <= 1'b0;
        cpu_level <= '0;
        cpu_code  <= '0;
      end
    end
  end

  // readback
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      for (int k = 0; k < PRIO_WORDS; k++)
        if (reg_addr == ADDR_W'(k)) reg_rdata <= prio_q[k*DATA_W +: DATA_W];
      if (reg_addr == ADDR_W'(A_MODE)) reg_rdata <= DATA_W'(mode_q);
      if (reg_addr == ADDR_W'(A_PEND)) reg_rdata <= DATA_W'(ext_pend);
      if (reg_addr == ADDR_W'(A_STAT)) reg_rdata <= DATA_W'({nmi_pend_q, nmi_rise_q, nmi_lvl});
      if (reg_addr == ADDR_W'(A_VEC))  reg_rdata <= DATA_W'(vec_q);
    end
  end

  // R6
  nmi_wins_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_pend_q |=> (cpu_req && cpu_code == NMI_CODE && cpu_level == '1));

  // R3
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_code != NMI_CODE) |-> (cpu_level > $past(cpu_mask)));

  // R8
  req_pin_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_pend_q |=> !req_out_n);

  // R9
  vec_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && cpu_req) |=> (vec_q == $past(cpu_code)));
endmodule

// File: tb/prio_intc_tb.sv
`timescale 1ns/1ps
module prio_intc_tb_top;
  localparam int NE = 4;
  localparam int NP = 4;
  localparam int NS = NE + NP;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [NE-1:0] ext_irq = '0;
  logic [NP-1:0] periph_irq = '0;
  logic        nmi_pin = 1'b0;
  logic [3:0]  cpu_mask = '0;
  logic        cpu_ack = 1'b0;
  logic        cpu_req;
  logic [3:0]  cpu_level;
  logic [3:0]  cpu_code;
  logic        req_out_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  prio_intc dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_irq(ext_irq),
    .periph_irq(periph_irq), .nmi_pin(nmi_pin), .cpu_mask(cpu_mask),
    .cpu_ack(cpu_ack), .cpu_req(cpu_req), .cpu_level(cpu_level),
    .cpu_code(cpu_code), .req_out_n(req_out_n));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_s1[NE+1], m_s2[NE+1], m_s3[NE+1];
  bit m_pend[NE];
  int m_mode[NE];
  int m_prio[NS];
  bit m_rise, m_npend;
  int m_vec;
  int e_req, e_lvl, e_code, e_outn, e_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= NE; i++) begin m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; end
      for (int i = 0; i < NE; i++) begin m_pend[i] = 0; m_mode[i] = 0; end
      for (int i = 0; i < NS; i++) m_prio[i] = 0;
      m_rise = 0; m_npend = 0; m_vec = 0;
      e_req = 0; e_lvl = 0; e_code = 0; e_outn = 1; e_rd = 0;
    end else begin
      int best, bi, rd, a;
      bit any, act, ackn, setb, nset;
      any = 0; best = 0; bi = 0;
      for (int i = 0; i < NS; i++) begin
        if (i < NE) act = (m_mode[i] >= 2) ? m_pend[i] : (m_mode[i] == 1 ? m_s2[i] : !m_s2[i]);
        else        act = periph_irq[i-NE];
        if (act && m_prio[i] != 0) begin
          any = 1;
          if (m_prio[i] > best) begin best = m_prio[i]; bi = i; end
        end
      end
      ackn = cpu_ack && e_req == 1 && e_code == NS;
      if (cpu_ack && e_req == 1) m_vec = e_code;
      a = reg_addr; rd = 0;
      if (a == 0) for (int i = 0; i < 4; i++) rd |= m_prio[i] << (4*i);
      if (a == 1) for (int i = 0; i < 4; i++) rd |= m_prio[4+i] << (4*i);
      if (a == 2) for (int i = 0; i < NE; i++) rd |= m_mode[i] << (2*i);
      if (a == 3) for (int i = 0; i < NE; i++) rd |= int'(m_pend[i]) << i;
      if (a == 4) rd = (int'(m_npend) << 2) | (int'(m_rise) << 1) | int'(m_s2[NE]);
      if (a == 5) rd = m_vec;
      e_rd   = rd;
      e_outn = (m_npend || any) ? 0 : 1;
      if (m_npend)                        begin e_req = 1; e_lvl = 15;   e_code = NS; end
      else if (any && best > int'(cpu_mask)) begin e_req = 1; e_lvl = best; e_code = bi; end
      else                                begin e_req = 0; e_lvl = 0;    e_code = 0;  end
      for (int i = 0; i < NE; i++) begin
        setb = (m_mode[i] == 2) ? (m_s2[i] && !m_s3[i]) :
               (m_mode[i] == 3) ? (!m_s2[i] && m_s3[i]) : 1'b0;
        if (setb) m_pend[i] = 1;
        else if (reg_we && reg_addr == 3 && reg_wdata[i]) m_pend[i] = 0;
      end
      nset = m_rise ? (m_s2[NE] && !m_s3[NE]) : (!m_s2[NE] && m_s3[NE]);
      if (nset) m_npend = 1; else if (ackn) m_npend = 0;
      if (reg_we) begin
        if (reg_addr == 0) for (int i = 0; i < 4; i++) m_prio[i]   = (reg_wdata >> (4*i)) & 15;
        if (reg_addr == 1) for (int i = 0; i < 4; i++) m_prio[4+i] = (reg_wdata >> (4*i)) & 15;
        if (reg_addr == 2) for (int i = 0; i < NE; i++) m_mode[i]  = (reg_wdata >> (2*i)) & 3;
        if (reg_addr == 4) m_rise = reg_wdata[1];
      end
      for (int i = 0; i <= NE; i++) begin
        m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i];
        m_s1[i] = (i < NE) ? ext_irq[i] : nmi_pin;
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 cpu_req model",   int'(cpu_req),   e_req);
      chk("R2 cpu_level model", int'(cpu_level), e_lvl);
      chk("R2 cpu_code model",  int'(cpu_code),  e_code);
      chk("R8 req_out_n model", int'(req_out_n), e_outn);
      chk("R5 reg_rdata model", int'(reg_rdata), e_rd);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 4'(a);
    @(negedge clk);
    d = int'(reg_rdata);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int v;
    cyc(4);
    rst = 1'b0;
    cyc(1);
    // R11 reset state
    chk("R11 cpu_req", int'(cpu_req), 0);
    chk("R11 req_out_n", int'(req_out_n), 1);
    rd(5, v); chk("R11 vector reg", v, 0);
    rd(0, v); chk("R11 prio reg", v, 0);

    // R1 zero priority blocks a source
    periph_irq = 4'b0001;
    cyc(2);
    chk("R1 zero prio req", int'(cpu_req), 0);
    chk("R1 zero prio pin", int'(req_out_n), 1);

    // R2 highest priority wins, tie goes to lower index
    wr(1, 16'h0095);
    periph_irq = 4'b0011;
    cyc(2);
    chk("R2 level", int'(cpu_level), 9);
    chk("R2 code", int'(cpu_code), 5);
    wr(1, 16'h0099);
    cyc(1);
    chk("R2 tie code", int'(cpu_code), 4);

    // R3 strict comparison with the mask
    cpu_mask = 4'd9;
    cyc(2);
    chk("R3 equal mask blocks", int'(cpu_req), 0);
    chk("R8 pin ignores mask", int'(req_out_n), 0);
    cpu_mask = 4'd8;
    cyc(2);
    chk("R3 lower mask passes", int'(cpu_req), 1);
    cpu_mask = 4'd0;
    periph_irq = '0;
    wr(1, 0);

    // R4 / R10 high-level pin 0, latency count
    wr(2, 16'h0001);
    wr(0, 16'h0003);
    cyc(2);
    @(negedge clk); ext_irq[0] = 1'b1;
    cyc(2);
    chk("R10 not yet after two edges", int'(cpu_req), 0);
    cyc(1);
    chk("R10 level due on third edge", int'(cpu_req), 1);
    chk("R4 level code", int'(cpu_code), 0);
    ext_irq[0] = 1'b0;
    cyc(4);
    chk("R4 level follows pin", int'(cpu_req), 0);

    // R5 rising edge on pin 1 held until write-1 clear
    wr(2, 16'h0009);
    wr(0, 16'h0063);
    @(negedge clk); ext_irq[1] = 1'b1;
    @(negedge clk); ext_irq[1] = 1'b0;
    cyc(6);
    chk("R5 edge held code", int'(cpu_code), 1);
    chk("R5 edge held level", int'(cpu_level), 6);
    rd(3, v); chk("R5 pending read", v, 2);
    wr(3, 16'h0002);
    cyc(2);
    chk("R5 cleared", int'(cpu_req), 0);
    rd(3, v); chk("R5 pending cleared", v, 0);

    // R4 falling mode on pin 2
    wr(2, 16'h0039);
    wr(0, 16'h0463);
    @(negedge clk); ext_irq[2] = 1'b1;
    cyc(4);
    chk("R4 no request on rise in fall mode", int'(cpu_req), 0);
    ext_irq[2] = 1'b0;
    cyc(6);
    chk("R4 falling edge code", int'(cpu_code), 2);
    wr(3, 16'h0004);
    cyc(2);

    // R7 pin level status, R6 falling-edge NMI
    nmi_pin = 1'b1;
    cyc(4);
    rd(4, v); chk("R7 level bit high", v & 1, 1);
    chk("R6 no NMI on rise when falling chosen", int'(cpu_req), 0);
    cpu_mask = 4'd15;
    nmi_pin = 1'b0;
    cyc(5);
    chk("R6 NMI req", int'(cpu_req), 1);
    chk("R6 NMI level", int'(cpu_level), 15);
    chk("R6 NMI code", int'(cpu_code), 8);
    chk("R8 NMI pin", int'(req_out_n), 0);
    rd(4, v); chk("R7 level bit low and pending", v & 5, 4);
    // R9 acknowledge latches the code
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
    cyc(2);
    chk("R6 NMI cleared by ack", int'(cpu_req), 0);
    rd(5, v); chk("R9 vector latched", v, 8);

    // R6 rising-edge selection
    wr(4, 16'h0002);
    @(negedge clk); nmi_pin = 1'b1;
    cyc(5);
    chk("R6 rising NMI", int'(cpu_code), 8);
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
    nmi_pin = 1'b0;
    cyc(6);
    chk("R6 rising NMI cleared", int'(cpu_req), 0);
    cpu_mask = 4'd0;

    // R9 maskable acknowledge
    periph_irq = 4'b0100;
    wr(1, 16'h0700);
    cyc(1);
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
    rd(5, v); chk("R9 peripheral vector", v, 6);
    periph_irq = '0;
    cyc(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule